// File: doc/BRIEF.md
# Four-Port Synchronous RAM

This block is a word-organised memory with four independent access ports that share one clock. Each port presents an address, a write-data word, a read/write select and a pair of enables of opposite polarity. All of these are captured in input registers on the rising clock edge. The access takes place on the following edge, and the read word is loaded into a per-port output register there. A read therefore returns its data after the second rising edge that follows the moment its request is presented.

Every port can read any word in any cycle, whatever the other ports are doing. A port may write a word in the same cycle that other ports read it, and those readers see the contents the word had before the write. If two or more ports write the same word in one cycle, only one of the written values is kept, and which one is not specified. A port is active only while both of its enables are asserted. An idle port draws no access from the array, ignores any write request, holds its last read word and drops its output enable. Once a port is active again, it needs one cycle of enabled input before its output enable comes back.

Top module: `quad_port_ram`

## Requirements
- R1: With both enables active and `rw_n` high, the word at the port's `addr` appears on that port's `rdata` after the second rising edge following the request, while all four ports read independently, including from one address.
- R2: With both enables active and `rw_n` low, the port stores `wdata` at `addr`, and a read of that address issued in the next cycle by any port returns the new word.
- R3: A port reading an address in the same cycle that another port writes it returns the contents from before the write.
- R4: A port is active only when `ce_n` is low and `ce` is high; the other three enable combinations make it idle.
- R5: An idle port ignores write requests, and its `rd_oe` is low after the second rising edge following an idle request.
- R6: After an idle period, one cycle of active enables with `rw_n` high brings `rd_oe` high, with valid data, after the second following rising edge.
- R7: `rd_oe` is high only for a read cycle. For a write cycle it is low, and `rdata` carries the word's previous contents.
- R8: While a port is idle, its `rdata` keeps the last word it read.
- R9: While `rst_n` is low, all `rd_oe` bits and all `rdata` words are zero. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all ports |
| rst_n | input | 1 | Active-low asynchronous reset of the port registers |
| ce_n | input | NP | Per-port enable, active low |
| ce | input | NP | Per-port enable, active high |
| rw_n | input | NP | Per-port select: 1 = read, 0 = write |
| addr | input | NP×AW | Per-port word address |
| wdata | input | NP×DW | Per-port write word |
| rdata | output | NP×DW | Per-port registered read word |
| rd_oe | output | NP | Per-port output enable (low = outputs released) |

## Verification
The array is first filled through all four ports. A reference model then follows a long stretch of seeded random traffic, with each port's enables, direction and address drawn independently and write addresses kept apart. This traffic distinguishes correct pipeline timing from a one-cycle-early or one-cycle-late output and exposes any cross-port interference. Directed sequences add cases the random traffic rarely produces: three readers on an address that is being written, which separates read-before-write from write-through; a write attempted through an idle port, which shows whether it leaks into the array; a walk through all four enable combinations; and a long idle period followed by a read, which pins down the one-cycle revive delay and the held output word.

// File: rtl/quad_port_ram.sv
module quad_port_ram #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int NP = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         ce_n,
  input  logic [NP-1:0]         ce,
  input  logic [NP-1:0]         rw_n,
  input  logic [NP-1:0][AW-1:0] addr,
  input  logic [NP-1:0][DW-1:0] wdata,
  output logic [NP-1:0][DW-1:0] rdata,
  output logic [NP-1:0]         rd_oe
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]         mem [DEPTH];
  logic [NP-1:0]         en_q, rw_q;
  logic [NP-1:0][AW-1:0] addr_q;
  logic [NP-1:0][DW-1:0] wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      rw_q   <= '1;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      en_q   <= ~ce_n & ce;
      rw_q   <= rw_n;
      addr_q <= addr;
      wd_q   <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++)
      if (en_q[p] && !rw_q[p]) mem[addr_q[p]] <= wd_q[p];
  end

  for (genvar g = 0; g < NP; g++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[g] <= '0;
        rd_oe[g] <= 1'b0;
      end else begin
        rd_oe[g] <= en_q[g] & rw_q[g];
        if (en_q[g]) rdata[g] <= mem[addr_q[g]];
      end
    end
  end
endmodule

module quad_port_ram_chk #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int NP = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NP-1:0]         ce_n,
  input logic [NP-1:0]         ce,
  input logic [NP-1:0]         rw_n,
  input logic [NP-1:0][DW-1:0] rdata,
  input logic [NP-1:0]         rd_oe
);
  logic [1:0]    cyc;
  logic [NP-1:0] en_in;
  assign en_in = ~ce_n & ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd0) |-> (rd_oe == '0));

  for (genvar g = 0; g < NP; g++) begin : g_chk
    p_idle_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && !$past(en_in[g], 2)) |-> !rd_oe[g]);
    p_write_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && $past(en_in[g], 2) && !$past(rw_n[g], 2)) |-> !rd_oe[g]);
    p_revive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && $past(en_in[g], 2) && $past(rw_n[g], 2)) |-> rd_oe[g]);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && !$past(en_in[g], 2)) |-> $stable(rdata[g]));
  end
endmodule

bind quad_port_ram quad_port_ram_chk #(.AW(AW), .DW(DW), .NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce(ce), .rw_n(rw_n),
  .rdata(rdata), .rd_oe(rd_oe)
);

// File: tb/quad_port_ram_tb.sv
module quad_port_ram_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NP = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]         ce_n = '1, ce = '0, rw_n = '1;
  logic [NP-1:0][AW-1:0] addr = '0;
  logic [NP-1:0][DW-1:0] wdata = '0;
  logic [NP-1:0][DW-1:0] rdata;
  logic [NP-1:0]         rd_oe;

  quad_port_ram #(.AW(AW), .DW(DW), .NP(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce(ce), .rw_n(rw_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_oe(rd_oe));

  always #4ns clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] mdl [DEPTH];
  bit            known [DEPTH];
  logic [NP-1:0]         n_cen, n_ce, n_rw;
  logic [NP-1:0][AW-1:0] n_addr;
  logic [NP-1:0][DW-1:0] n_wd;
  logic [NP-1:0]         p_en = '0, p_rw = '1, pp_en = '0;
  logic [NP-1:0][AW-1:0] p_addr = '0;
  logic [NP-1:0][DW-1:0] p_wd = '0;
  logic [NP-1:0][DW-1:0] e_rd = '0;
  logic [NP-1:0]         e_oe = '0;
  bit   [NP-1:0]         e_kn = '1;
  string tag [NP];
  string note = "";

  function automatic bit active(logic cn, logic c);
    return !cn && c;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, note, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk(rd_oe[p] === e_oe[p], (tag[p] == "R8") ? "R5" : tag[p],
          DW'(rd_oe[p]), DW'(e_oe[p]));
      if (e_kn[p]) chk(rdata[p] === e_rd[p], tag[p], rdata[p], e_rd[p]);
    end
    for (int p = 0; p < NP; p++) begin
      if (!p_en[p]) begin
        e_oe[p] = 1'b0;
        tag[p] = "R8";
      end else begin
        e_rd[p] = mdl[p_addr[p]];
        e_kn[p] = known[p_addr[p]];
        e_oe[p] = p_rw[p];
        tag[p] = !pp_en[p] ? "R6" : "R1";
        if (!p_rw[p]) tag[p] = "R7";
        else
          for (int q = 0; q < NP; q++)
            if (q != p && p_en[q] && !p_rw[q] && p_addr[q] == p_addr[p]) tag[p] = "R3";
      end
    end
    for (int p = 0; p < NP; p++)
      if (p_en[p] && !p_rw[p]) begin
        mdl[p_addr[p]] = p_wd[p];
        known[p_addr[p]] = 1;
      end
    pp_en = p_en;
    for (int p = 0; p < NP; p++) p_en[p] = active(n_cen[p], n_ce[p]);
    p_rw = n_rw; p_addr = n_addr; p_wd = n_wd;
    ce_n = n_cen; ce = n_ce; rw_n = n_rw; addr = n_addr; wdata = n_wd;
  endtask

  task automatic set_all(bit en, bit rd);
    n_cen = en ? '0 : '1;
    n_ce  = en ? '1 : '0;
    n_rw  = rd ? '1 : '0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    for (int p = 0; p < NP; p++) tag[p] = "R9";
    n_addr = '0; n_wd = '0;
    set_all(0, 1);
    repeat (3) @(negedge clk);
    note = "reset";
    for (int p = 0; p < NP; p++) begin
      chk(rd_oe[p] === 1'b0, "R9", DW'(rd_oe[p]), '0);
      chk(rdata[p] === '0, "R9", rdata[p], '0);
    end
    rst_n = 1'b1;

    note = "fill R2";
    for (int i = 0; i < DEPTH / NP; i++) begin
      set_all(1, 0);
      for (int p = 0; p < NP; p++) begin
        n_addr[p] = AW'(i * NP + p);
        n_wd[p] = DW'($urandom);
      end
      cycle();
    end

    note = "R3 read-before-write";
    set_all(1, 1);
    n_addr = {NP{AW'(7)}};
    n_rw[0] = 1'b0; n_wd[0] = 16'hA5C3;
    cycle();
    note = "R2 read-after-write";
    set_all(1, 1);
    cycle();

    note = "R5 idle write";
    set_all(1, 1);
    n_cen[2] = 1'b1; n_rw[2] = 1'b0; n_addr[2] = AW'(9); n_wd[2] = 16'h1234;
    cycle();
    set_all(1, 1);
    n_addr = {NP{AW'(9)}};
    cycle();

    note = "R4 enable combos";
    for (int k = 0; k < 4; k++) begin
      set_all(1, 1);
      n_cen[3] = k[0]; n_ce[3] = k[1];
      n_addr[3] = AW'(k + 20);
      cycle();
    end

    note = "R6 revive";
    set_all(1, 1);
    n_ce[1] = 1'b0;
    repeat (4) cycle();
    set_all(1, 1);
    n_addr[1] = AW'(33);
    cycle();
    set_all(1, 1);
    cycle();

    note = "random";
    void'($urandom(32'd12345));
    for (int c = 0; c < 4000; c++) begin
      for (int p = 0; p < NP; p++) begin
        n_cen[p] = ($urandom_range(0, 99) < 12);
        n_ce[p]  = ($urandom_range(0, 99) >= 12);
        n_rw[p]  = ($urandom_range(0, 99) >= 35);
        n_addr[p] = AW'($urandom_range(0, (c % 3 == 0) ? 3 : DEPTH - 1));
        n_wd[p] = DW'($urandom);
        for (int q = 0; q < p; q++)
          if (!n_rw[p] && !n_rw[q] && n_addr[q] == n_addr[p]) n_rw[p] = 1'b1;
      end
      cycle();
    end
    set_all(0, 1);
    repeat (3) cycle();

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8ns * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule